// File: doc/BRIEF.md
# Nibble-Wide Double-Data-Rate Link Transmitter

This block moves 128-bit quad-words across a point-to-point link made of a 4-bit data bus, a forwarded clock and a single acknowledge line from the far end. A producer on the core side hands quad-words in through a valid/ready write port. The block stages them in a two-entry buffer, so the next word can be loaded while the current one is on the wire.

The serialiser puts one nibble on the bus for every transition of the forwarded clock, rising and falling alike. A quad-word therefore takes 32 nibbles, or 16 link clock periods. The link clock is derived from the core clock by a programmable divisor. A new quad-word is started only while the receiver holds acknowledge high.

Words are grouped into blocks of programmable length. When configured to, the block appends one checksum word to each block. A one-cycle block-complete strobe marks the end of every block.

Top module: `lnk_nib_tx`

## Requirements
- R1: After reset, `lk_clk` is 0, `lk_dat` is 0, `lk_bcmp` is 0 and `wr_ready` is 1.
- R2: Each quad-word is sent as 32 nibbles, bits [3:0] first and bits [127:124] last. Every transition of `lk_clk` presents the next nibble on `lk_dat`, and the first nibble of a word is presented with a rising edge.
- R3: Each nibble, and so each half-period of `lk_clk`, lasts exactly `cfg_div`+1 core clock cycles.
- R4: The buffer holds at most two quad-words, and `wr_ready` is high exactly when fewer than two are held. A write offered while `wr_ready` is low is dropped and never appears on the link.
- R5: No quad-word starts while `lk_ack` is low. A word already in flight runs to its end regardless of `lk_ack`.
- R6: When the next word is available and `lk_ack` is high as a word ends, the next word's first nibble follows after one normal half-period, with no idle gap.
- R7: A block is `cfg_blk_len`+1 data words. `lk_bcmp` pulses high for exactly one cycle, right after the last half-period of the block's final word, and that final word is the checksum word when one is sent.
- R8: With `cfg_csum_en` high, one extra word follows each block's data words. Its bits [7:0] are the sum, modulo 256, of all 16 bytes of every data word in the block, and its bits [127:8] are zero.
- R9: Whenever no word is being sent, `lk_clk` is low and `lk_dat` is zero, and `lk_clk` ends every word low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 4 | Half-period of the link clock minus one, in core cycles |
| cfg_blk_len | input | 6 | Data words per block minus one |
| cfg_csum_en | input | 1 | Append a checksum word to each block |
| wr_valid | input | 1 | Write port offers a quad-word |
| wr_data | input | 128 | Quad-word being offered |
| wr_ready | output | 1 | Buffer can accept a quad-word |
| lk_ack | input | 1 | Receiver permits a new quad-word to start |
| lk_clk | output | 1 | Forwarded link clock |
| lk_dat | output | 4 | Link data nibble |
| lk_bcmp | output | 1 | One-cycle block-complete strobe |

## Verification
The hardest case to reach from the ports is acknowledge being withdrawn in the middle of a word while the second buffer entry is already full and a further write is being offered. The bench sets this up by counting the forwarded clock transitions it has decoded and dropping `lk_ack` a few nibbles into the first word. It then checks that this word completes, that the next one does not start, and that the rejected write never appears on the link. Back-to-back streaming through a checksum word is exercised by offering three words while the buffer is still draining, so that every word boundary and the checksum hand-off must happen with no gap.

// File: rtl/lnk_tx_pkg.sv
package lnk_tx_pkg;
  localparam int QW_W   = 128;
  localparam int NIB_W  = 4;
  localparam int NIBS   = QW_W / NIB_W;
  localparam int NIB_IW = $clog2(NIBS);
  localparam int BYTES  = QW_W / 8;

  typedef logic [QW_W-1:0] qw_t;

  // modulo-256 sum of all bytes of a quad-word
  function automatic logic [7:0] qw_byte_sum(input qw_t w);
    logic [7:0] s;
    s = '0;
    for (int i = 0; i < BYTES; i++) s = s + w[i*8 +: 8];
    return s;
  endfunction
endpackage

// File: rtl/lnk_qw_buf.sv
module lnk_qw_buf
  import lnk_tx_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  qw_t           push_data,
  input  logic          pop,
  output qw_t           head,
  output logic          not_empty,
  output logic          not_full,
  output logic [CW-1:0] level
);
  qw_t           mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign not_empty = (cnt != '0);
  assign not_full  = (cnt != CW'(DEPTH));
  assign push_ok   = push && not_full;
  assign pop_ok    = pop && not_empty;
  assign head      = mem[rd_ptr];
  assign level     = cnt;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      if (pop_ok)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/lnk_blk_seq.sv
module lnk_blk_seq
  import lnk_tx_pkg::*;
#(
  parameter int BLK_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] cfg_len,
  input  logic             cfg_csum_en,
  input  logic             buf_ne,
  input  qw_t              buf_head,
  input  logic             take,
  output logic             nxt_avail,
  output qw_t              nxt_word,
  output logic             nxt_last,
  output logic             buf_pop
);
  logic [BLK_W-1:0] qw_cnt;
  logic [7:0]       sum_r;
  logic             csum_pend;
  logic             last_data;

  assign last_data = (qw_cnt == cfg_len);

  always_comb begin
    if (csum_pend) begin
      nxt_avail = 1'b1;
      nxt_word  = {{(QW_W-8){1'b0}}, sum_r};
      nxt_last  = 1'b1;
    end else begin
      nxt_avail = buf_ne;
      nxt_word  = buf_head;
      nxt_last  = last_data && !cfg_csum_en;
    end
  end

  assign buf_pop = take && !csum_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qw_cnt    <= '0;
      sum_r     <= '0;
      csum_pend <= 1'b0;
    end else if (take) begin
      if (csum_pend) begin
        csum_pend <= 1'b0;
        sum_r     <= '0;
      end else if (last_data) begin
        qw_cnt    <= '0;
        csum_pend <= cfg_csum_en;
        sum_r     <= cfg_csum_en ? sum_r + qw_byte_sum(buf_head) : '0;
      end else begin
        qw_cnt <= qw_cnt + BLK_W'(1);
        sum_r  <= sum_r + qw_byte_sum(buf_head);
      end
    end
  end
endmodule

// File: rtl/lnk_nib_ser.sv
module lnk_nib_ser
  import lnk_tx_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             lk_ack,
  input  logic             nxt_avail,
  input  qw_t              nxt_word,
  input  logic             nxt_last,
  output logic             take,
  output logic             busy,
  output logic [DIV_W-1:0] hcnt_o,
  output logic             lk_clk,
  output logic [NIB_W-1:0] lk_dat,
  output logic             blk_done
);
  qw_t               shreg;
  logic [NIB_IW-1:0] nib_idx;
  logic [DIV_W-1:0]  hcnt;
  logic              busy_r, clk_r, cur_last, done_r;
  logic              half_end, word_end;

  assign half_end = busy_r && (hcnt == cfg_div);
  assign word_end = half_end && (nib_idx == NIB_IW'(NIBS - 1));
  assign take     = nxt_avail && lk_ack && (!busy_r || word_end);

  assign busy     = busy_r;
  assign hcnt_o   = hcnt;
  assign lk_clk   = clk_r;
  assign lk_dat   = busy_r ? shreg[NIB_W-1:0] : '0;
  assign blk_done = done_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_r   <= 1'b0;
      shreg    <= '0;
      nib_idx  <= '0;
      hcnt     <= '0;
      clk_r    <= 1'b0;
      cur_last <= 1'b0;
      done_r   <= 1'b0;
    end else begin
      done_r <= word_end && cur_last;
      if (take) begin
        busy_r   <= 1'b1;
        shreg    <= nxt_word;
        nib_idx  <= '0;
        hcnt     <= '0;
        clk_r    <= 1'b1;
        cur_last <= nxt_last;
      end else if (word_end) begin
        busy_r <= 1'b0;
        hcnt   <= '0;
        clk_r  <= 1'b0;
      end else if (half_end) begin
        hcnt    <= '0;
        nib_idx <= nib_idx + NIB_IW'(1);
        shreg   <= shreg >> NIB_W;
        clk_r   <= ~clk_r;
      end else if (busy_r) begin
        hcnt <= hcnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/lnk_nib_tx.sv
module lnk_nib_tx
  import lnk_tx_pkg::*;
#(
  parameter int BUF_DEPTH = 2,
  parameter int DIV_W     = 4,
  parameter int BLK_W     = 6,
  localparam int BUF_CW   = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [BLK_W-1:0] cfg_blk_len,
  input  logic             cfg_csum_en,
  input  logic             wr_valid,
  input  logic [QW_W-1:0]  wr_data,
  output logic             wr_ready,
  input  logic             lk_ack,
  output logic             lk_clk,
  output logic [NIB_W-1:0] lk_dat,
  output logic             lk_bcmp
);
  qw_t              buf_head, nxt_word;
  logic             buf_ne, buf_nf, buf_pop, buf_push;
  logic [BUF_CW-1:0] buf_level;
  logic             nxt_avail, nxt_last;
  logic             ser_take, ser_busy;
  logic [DIV_W-1:0] ser_hcnt;

  assign buf_push = wr_valid && buf_nf;
  assign wr_ready = buf_nf;

  lnk_qw_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (buf_push),
    .push_data (wr_data),
    .pop       (buf_pop),
    .head      (buf_head),
    .not_empty (buf_ne),
    .not_full  (buf_nf),
    .level     (buf_level)
  );

  lnk_blk_seq #(.BLK_W(BLK_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_len     (cfg_blk_len),
    .cfg_csum_en (cfg_csum_en),
    .buf_ne      (buf_ne),
    .buf_head    (buf_head),
    .take        (ser_take),
    .nxt_avail   (nxt_avail),
    .nxt_word    (nxt_word),
    .nxt_last    (nxt_last),
    .buf_pop     (buf_pop)
  );

  lnk_nib_ser #(.DIV_W(DIV_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_div   (cfg_div),
    .lk_ack    (lk_ack),
    .nxt_avail (nxt_avail),
    .nxt_word  (nxt_word),
    .nxt_last  (nxt_last),
    .take      (ser_take),
    .busy      (ser_busy),
    .hcnt_o    (ser_hcnt),
    .lk_clk    (lk_clk),
    .lk_dat    (lk_dat),
    .blk_done  (lk_bcmp)
  );
endmodule

// File: rtl/lnk_tx_chk.sv
module lnk_tx_chk #(
  parameter int DIV_W = 4,
  parameter int LW    = 2,
  parameter int DEPTH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             lk_ack,
  input logic             lk_clk,
  input logic [3:0]       lk_dat,
  input logic             lk_bcmp,
  input logic             ser_busy,
  input logic             ser_take,
  input logic             buf_pop,
  input logic [LW-1:0]    buf_level,
  input logic [DIV_W-1:0] ser_hcnt,
  input logic [DIV_W-1:0] cfg_div
);
  assert_full_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_level == LW'(DEPTH)) |-> !wr_ready);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !buf_pop) |=> (buf_level == $past(buf_level)));

  assert_ack_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_take |-> lk_ack);

  assert_first_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_take |=> lk_clk);

  assert_half_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_busy |-> (ser_hcnt <= cfg_div));

  assert_bcmp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_bcmp |=> !lk_bcmp);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_busy |-> (!lk_clk && lk_dat == 4'h0));
endmodule

bind lnk_nib_tx lnk_tx_chk #(.DIV_W(DIV_W), .LW(BUF_CW), .DEPTH(BUF_DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .lk_ack    (lk_ack),
  .lk_clk    (lk_clk),
  .lk_dat    (lk_dat),
  .lk_bcmp   (lk_bcmp),
  .ser_busy  (ser_busy),
  .ser_take  (ser_take),
  .buf_pop   (buf_pop),
  .buf_level (buf_level),
  .ser_hcnt  (ser_hcnt),
  .cfg_div   (cfg_div)
);

// File: tb/tb_lnk_nib_tx.sv
module tb_lnk_nib_tx;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   cfg_div = 4'd0;
  logic [5:0]   cfg_blk_len = 6'd0;
  logic         cfg_csum_en = 1'b0;
  logic         wr_valid = 1'b0;
  logic [127:0] wr_data = '0;
  logic         wr_ready;
  logic         lk_ack = 1'b1;
  logic         lk_clk;
  logic [3:0]   lk_dat;
  logic         lk_bcmp;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lnk_nib_tx dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_blk_len(cfg_blk_len),
    .cfg_csum_en(cfg_csum_en), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .lk_ack(lk_ack), .lk_clk(lk_clk), .lk_dat(lk_dat),
    .lk_bcmp(lk_bcmp)
  );

  // link receiver model: decode one nibble per lk_clk transition
  int cyc = 0, last_tgl = -1000, ni = 0;
  int tgl_n = 0, rx_n = 0, bcmp_n = 0, bcmp_at = 0;
  int ivl_bad = 0, edge_bad = 0, b2b_cnt = 0;
  logic prev_clk = 1'b0;
  logic [127:0] cur = '0;
  logic [127:0] rx_q [16];

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (lk_clk !== prev_clk) begin
        tgl_n++;
        if (ni == 0) begin
          if (lk_clk !== 1'b1) edge_bad++;
          if (cyc - last_tgl == int'(cfg_div) + 1) b2b_cnt++;
          cur = '0;
        end else if (cyc - last_tgl != int'(cfg_div) + 1) ivl_bad++;
        cur[ni*4 +: 4] = lk_dat;
        if (ni == 31) begin
          if (rx_n < 16) rx_q[rx_n] = cur;
          rx_n++;
          ni = 0;
        end else ni++;
        last_tgl = cyc;
      end
      prev_clk = lk_clk;
      if (lk_bcmp === 1'b1) begin
        bcmp_n++;
        bcmp_at = rx_n;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    @(posedge clk); #1;
    tgl_n = 0; rx_n = 0; bcmp_n = 0; bcmp_at = 0;
    ivl_bad = 0; edge_bad = 0; b2b_cnt = 0;
  endtask

  task automatic push_word(input logic [127:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_bcmp(input int n);
    while (bcmp_n < n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] ref_sum(input logic [127:0] w);
    int acc;
    acc = 0;
    for (int i = 0; i < 16; i++) acc += int'(w[127 - i*8 -: 8]);
    return 8'(acc % 256);
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check(lk_clk === 1'b0, "R1 lk_clk", 128'(lk_clk), 128'd0);
    check(lk_dat === 4'h0, "R1 lk_dat", 128'(lk_dat), 128'd0);
    check(lk_bcmp === 1'b0, "R1 lk_bcmp", 128'(lk_bcmp), 128'd0);
    check(wr_ready === 1'b1, "R1 wr_ready", 128'(wr_ready), 128'd1);
  endtask

  task automatic t_single();
    logic [127:0] a = 128'h0123456789abcdeffedcba9876543210;
    cfg_div = 4'd0; cfg_blk_len = 6'd0; cfg_csum_en = 1'b0;
    clr_mon();
    push_word(a);
    wait_bcmp(1);
    check(rx_q[0] === a, "R2 nibble order", rx_q[0], a);
    check(edge_bad == 0, "R2 first edge rising", 128'(edge_bad), 128'd0);
    check(ivl_bad == 0, "R3 half-period div0", 128'(ivl_bad), 128'd0);
    check(bcmp_n == 1 && bcmp_at == 1, "R7 single-word block", 128'(bcmp_at), 128'd1);
    check(lk_clk === 1'b0 && lk_dat === 4'h0, "R9 idle after word", {lk_clk, lk_dat}, 128'd0);
  endtask

  task automatic t_csum();
    logic [127:0] w [3];
    logic [7:0] s;
    w[0] = 128'hffffffffffffffffffffffffffffffff;
    w[1] = 128'h00112233445566778899aabbccddeeff;
    w[2] = 128'h800000000000000000000000000000a5;
    s = ref_sum(w[0]) + ref_sum(w[1]) + ref_sum(w[2]);
    cfg_div = 4'd2; cfg_blk_len = 6'd2; cfg_csum_en = 1'b1;
    clr_mon();
    fork
      begin push_word(w[0]); push_word(w[1]); push_word(w[2]); end
    join
    wait_bcmp(1);
    check(rx_n == 4, "R8 word count with checksum", 128'(rx_n), 128'd4);
    for (int i = 0; i < 3; i++)
      check(rx_q[i] === w[i], "R2 data word", rx_q[i], w[i]);
    check(rx_q[3] === {120'd0, s}, "R8 checksum word", rx_q[3], {120'd0, s});
    check(bcmp_at == 4, "R7 strobe after checksum", 128'(bcmp_at), 128'd4);
    check(ivl_bad == 0, "R3 half-period div2", 128'(ivl_bad), 128'd0);
    check(b2b_cnt == 3, "R6 gapless boundaries", 128'(b2b_cnt), 128'd3);
  endtask

  task automatic t_ack_idle();
    logic [127:0] b = 128'h1111222233334444555566667777aaaa;
    logic [127:0] c = 128'h9999888877776666555544443333cccc;
    logic [127:0] d = 128'hdeaddeaddeaddeaddeaddeaddeaddead;
    cfg_div = 4'd1; cfg_blk_len = 6'd1; cfg_csum_en = 1'b0;
    lk_ack = 1'b0;
    clr_mon();
    push_word(b);
    push_word(c);
    @(negedge clk);
    check(wr_ready === 1'b0, "R4 ready low when full", 128'(wr_ready), 128'd0);
    wr_valid = 1'b1; wr_data = d;
    repeat (5) @(negedge clk);
    wr_valid = 1'b0;
    repeat (50) @(negedge clk);
    check(tgl_n == 0 && lk_dat === 4'h0, "R5 no start without ack", 128'(tgl_n), 128'd0);
    lk_ack = 1'b1;
    wait_bcmp(1);
    check(rx_n == 2, "R4 rejected write absent", 128'(rx_n), 128'd2);
    check(rx_q[0] === b && rx_q[1] === c, "R4 buffered order", rx_q[1], c);
  endtask

  task automatic t_ack_mid();
    logic [127:0] e = 128'h0f0e0d0c0b0a09080706050403020100;
    logic [127:0] f = 128'hf0e0d0c0b0a090807060504030201000;
    logic [127:0] g = 128'h5a5a5a5a5a5a5a5a5a5a5a5a5a5a5a5a;
    cfg_div = 4'd1; cfg_blk_len = 6'd1; cfg_csum_en = 1'b0;
    clr_mon();
    push_word(e);
    push_word(f);
    while (tgl_n < 5) @(negedge clk);
    lk_ack = 1'b0;
    // buffer holds f; offer g while ack is low
    push_word(g);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 128'hbad0bad0bad0bad0bad0bad0bad0bad0;
    check(wr_ready === 1'b0, "R4 ready low with two held", 128'(wr_ready), 128'd0);
    repeat (3) @(negedge clk);
    wr_valid = 1'b0;
    while (rx_n < 1) @(negedge clk);
    repeat (40) @(negedge clk);
    check(rx_n == 1 && tgl_n == 32, "R5 in-flight word completes, next held", 128'(tgl_n), 128'd32);
    check(rx_q[0] === e, "R5 in-flight word intact", rx_q[0], e);
    lk_ack = 1'b1;
    wait_bcmp(1);
    while (rx_n < 3) @(negedge clk);
    repeat (10) @(negedge clk);
    check(rx_q[1] === f && rx_q[2] === g, "R4 drop while full", rx_q[2], g);
    check(rx_n == 3, "R4 rejected write never sent", 128'(rx_n), 128'd3);
    check(lk_clk === 1'b0 && lk_dat === 4'h0, "R9 idle after stream", {lk_clk, lk_dat}, 128'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_single();
    t_csum();
    t_ack_idle();
    t_ack_mid();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule